// File: doc/BRIEF.md
# Fuse Range CRC-32 Checker

This block checks the integrity of a window of one-time-programmable fuse words. Software loads a configuration word with a first and a last fuse word address, plus the place where the expected CRC is stored. It then sets a go bit. The block reads every word in the window through a synchronous word-read port and folds each word into a CRC-32 accumulator. Next it reads the stored reference word and compares it with the finished CRC. The finished CRC is kept in a result register. A mismatch raises a fail flag that stays set until software clears it.

The reference location is either a base address plus a 3-bit selector, or one fixed recommended address when the fixed-location enable is set. The fuse array is outside the block. A read issued in one cycle returns its word on `fuse_rd_data_i` in the next cycle.

Top module: `fuse_crc_checker`

## Requirements
- R1: Reset is synchronous and active high. After reset, `busy_o`, `go_o` and `fail_o` are 0, and `crc_result_o` and `cfg_rdata` are all zero.
- R2: The configuration register has the following layout. Bits 7:0 hold the first address, bits 15:8 the last address, bits 18:16 the reference selector, and bit 19 the fixed-location enable. It reads back on `cfg_rdata`. A write made while `busy_o` is high is ignored.
- R3: A control write with `ctl_go_in`=1 while idle sets `go_o` and `busy_o` in the next cycle. A control write with `ctl_go_in`=1 while busy does not restart or lengthen the check.
- R4: The CRC-32 uses the reflected polynomial 0xEDB88320, seed 0xFFFFFFFF and final XOR 0xFFFFFFFF. Each 32-bit word is consumed least-significant byte first. Words are taken in ascending address order from first to last, both inclusive. The finished value is loaded into `crc_result_o` when the check ends.
- R5: The reference word is read from address FIXED_REF_ADDR (default 0xE8) when the fixed enable is 1. Otherwise it is read from REF_BASE + selector (default base 0xF0). A finished CRC that differs from the reference word sets `fail_o`.
- R6: `fail_o` is sticky. A matching check leaves it unchanged. A control write with `ctl_fail_in`=0 clears it. A control write with `ctl_fail_in`=1 has no effect on it.
- R7: When the first address is greater than the last, no fuse read is issued and `busy_o` is high for exactly one cycle. `fail_o` is set and `crc_result_o` becomes 0.
- R8: A window of N words keeps `busy_o` high for exactly 2N+2 cycles. `go_o` is high exactly while `busy_o` is high and drops by itself at completion.
- R9: If a mismatch (or an empty window) completes in the same cycle as a software clear of `fail_o`, the hardware set wins and `fail_o` stays 1. A clear that coincides with a matching completion takes effect.
- R10: A window of N words issues exactly N+1 fuse reads: one per word, then one for the reference. No read is issued while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 20 | Configuration write value |
| cfg_rdata | output | 20 | Configuration readback |
| ctl_wr | input | 1 | Control write strobe |
| ctl_go_in | input | 1 | Control write: 1 requests a check |
| ctl_fail_in | input | 1 | Control write: 0 clears the fail flag |
| go_o | output | 1 | Go bit, self-clearing |
| busy_o | output | 1 | High while a check runs |
| fail_o | output | 1 | Sticky mismatch flag |
| crc_result_o | output | 32 | Last finished CRC-32 |
| fuse_rd_en_o | output | 1 | Fuse read request |
| fuse_rd_addr_o | output | 8 | Fuse word address |
| fuse_rd_data_i | input | 32 | Fuse word, valid the cycle after a request |

## Verification
Two events can land in the same cycle: the comparison that ends a check and a software write that clears the fail flag. The bench counts cycles from the go write so that the clearing write falls exactly in the comparison cycle. It does this once with a corrupted reference word, where the flag must stay set, and once with a correct reference word, where the clear must win. The remaining runs draw windows, selectors and fuse contents at random, and the bench compares the result register and the fail flag against a byte-wise CRC-32 model of its own.

// File: rtl/fcrc_pkg.sv
package fcrc_pkg;
    localparam int ADDR_W = 8;
    localparam int SEL_W  = 3;
    localparam int WORD_W = 32;
    localparam int CFG_W  = 2 * ADDR_W + SEL_W + 1;

    localparam logic [WORD_W-1:0] CRC_POLY   = 32'hEDB8_8320;
    localparam logic [WORD_W-1:0] CRC_SEED   = 32'hFFFF_FFFF;
    localparam logic [WORD_W-1:0] CRC_XOROUT = 32'hFFFF_FFFF;

    typedef struct packed {
        logic              use_fixed;
        logic [SEL_W-1:0]  ref_sel;
        logic [ADDR_W-1:0] last;
        logic [ADDR_W-1:0] first;
    } cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_FOLD,
        ST_REF_ISSUE,
        ST_REF_CMP,
        ST_EMPTY
    } walk_state_e;

    // Reflected CRC-32 over one word, bit 0 first (equals LSB byte first).
    function automatic logic [WORD_W-1:0] crc32_fold(
        input logic [WORD_W-1:0] crc_in,
        input logic [WORD_W-1:0] word
    );
        logic [WORD_W-1:0] c;
        c = crc_in;
        for (int i = 0; i < WORD_W; i++) begin
            if (c[0] ^ word[i]) c = (c >> 1) ^ CRC_POLY;
            else                c = c >> 1;
        end
        return c;
    endfunction
endpackage

// File: rtl/fcrc_ref_sel.sv
module fcrc_ref_sel
    import fcrc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REF_BASE       = 8'hF0,
    parameter logic [ADDR_W-1:0] FIXED_REF_ADDR = 8'hE8
) (
    input  logic              use_fixed,
    input  logic [SEL_W-1:0]  ref_sel,
    output logic [ADDR_W-1:0] ref_addr
);
    localparam int PAD_W = ADDR_W - SEL_W;

    always_comb begin
        if (use_fixed) ref_addr = FIXED_REF_ADDR;
        else           ref_addr = REF_BASE + {{PAD_W{1'b0}}, ref_sel};
    end
endmodule

// File: rtl/fcrc_walker.sv
module fcrc_walker
    import fcrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  cfg_t              cfg,
    input  logic [ADDR_W-1:0] ref_addr,
    output logic              busy,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              seed_en,
    output logic              fold_en,
    output logic              finish_cmp,
    output logic              finish_empty
);
    walk_state_e       state_q;
    logic [ADDR_W-1:0] cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (launch) begin
                    cur_q   <= cfg.first;
                    state_q <= (cfg.first > cfg.last) ? ST_EMPTY : ST_ISSUE;
                end
                ST_ISSUE: state_q <= ST_FOLD;
                ST_FOLD: begin
                    if (cur_q == cfg.last) begin
                        state_q <= ST_REF_ISSUE;
                    end else begin
                        cur_q   <= cur_q + ADDR_W'(1);
                        state_q <= ST_ISSUE;
                    end
                end
                ST_REF_ISSUE: state_q <= ST_REF_CMP;
                ST_REF_CMP:   state_q <= ST_IDLE;
                ST_EMPTY:     state_q <= ST_IDLE;
                default:      state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy         = (state_q != ST_IDLE);
        rd_en        = (state_q == ST_ISSUE) || (state_q == ST_REF_ISSUE);
        rd_addr      = (state_q == ST_REF_ISSUE) ? ref_addr : cur_q;
        seed_en      = launch && (state_q == ST_IDLE);
        fold_en      = (state_q == ST_FOLD);
        finish_cmp   = (state_q == ST_REF_CMP);
        finish_empty = (state_q == ST_EMPTY);
    end

    // R10: word reads stay inside the configured window
    assert_read_in_window_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ISSUE) |-> (cur_q >= cfg.first && cur_q <= cfg.last));

    // R7: an inverted window never touches the fuse port
    assert_empty_no_read_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EMPTY) |-> (!rd_en && $past(launch)));
endmodule

// File: rtl/fcrc_accum.sv
module fcrc_accum
    import fcrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              seed_en,
    input  logic              fold_en,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] crc_final
);
    logic [WORD_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst)          crc_q <= CRC_SEED;
        else if (seed_en) crc_q <= CRC_SEED;
        else if (fold_en) crc_q <= crc32_fold(crc_q, word);
    end

    assign crc_final = crc_q ^ CRC_XOROUT;

    // R4: every check starts from the seed
    assert_seeded_R4: assert property (@(posedge clk) disable iff (rst)
        seed_en |=> (crc_q == CRC_SEED));
endmodule

// File: rtl/fcrc_status.sv
module fcrc_status
    import fcrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              ctl_wr,
    input  logic              ctl_fail_in,
    input  logic              finish_cmp,
    input  logic              finish_empty,
    input  logic [WORD_W-1:0] crc_final,
    input  logic [WORD_W-1:0] ref_word,
    output logic              go,
    output logic              fail,
    output logic [WORD_W-1:0] result
);
    logic finish, hw_set, sw_clr;

    always_comb begin
        finish = finish_cmp || finish_empty;
        hw_set = finish_empty || (finish_cmp && (crc_final != ref_word));
        sw_clr = ctl_wr && !ctl_fail_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            go     <= 1'b0;
            fail   <= 1'b0;
            result <= '0;
        end else begin
            if (finish)      go <= 1'b0;
            else if (launch) go <= 1'b1;

            if (hw_set)      fail <= 1'b1;
            else if (sw_clr) fail <= 1'b0;

            if (finish) result <= crc_final;
        end
    end

    // R6: the flag only drops through a software clear
    assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (fail && !(ctl_wr && !ctl_fail_in)) |=> fail);

    // R9: hardware set beats a coincident clear
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (finish_cmp && (crc_final != ref_word)) |=> fail);
endmodule

// File: rtl/fuse_crc_checker.sv
module fuse_crc_checker
    import fcrc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REF_BASE       = 8'hF0,
    parameter logic [ADDR_W-1:0] FIXED_REF_ADDR = 8'hE8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              ctl_wr,
    input  logic              ctl_go_in,
    input  logic              ctl_fail_in,
    output logic              go_o,
    output logic              busy_o,
    output logic              fail_o,
    output logic [WORD_W-1:0] crc_result_o,
    output logic              fuse_rd_en_o,
    output logic [ADDR_W-1:0] fuse_rd_addr_o,
    input  logic [WORD_W-1:0] fuse_rd_data_i
);
    cfg_t              cfg_q;
    logic [ADDR_W-1:0] ref_addr;
    logic              launch, seed_en, fold_en, finish_cmp, finish_empty;
    logic [WORD_W-1:0] crc_final;

    always_ff @(posedge clk) begin
        if (rst)                    cfg_q <= '0;
        else if (cfg_wr && !busy_o) cfg_q <= cfg_t'(cfg_wdata);
    end

    assign cfg_rdata = cfg_q;
    assign launch    = ctl_wr && ctl_go_in && !busy_o;

    fcrc_ref_sel #(
        .REF_BASE       (REF_BASE),
        .FIXED_REF_ADDR (FIXED_REF_ADDR)
    ) ref_sel_i (
        .use_fixed (cfg_q.use_fixed),
        .ref_sel   (cfg_q.ref_sel),
        .ref_addr  (ref_addr)
    );

    fcrc_walker walker_i (
        .clk          (clk),
        .rst          (rst),
        .launch       (launch),
        .cfg          (cfg_q),
        .ref_addr     (ref_addr),
        .busy         (busy_o),
        .rd_en        (fuse_rd_en_o),
        .rd_addr      (fuse_rd_addr_o),
        .seed_en      (seed_en),
        .fold_en      (fold_en),
        .finish_cmp   (finish_cmp),
        .finish_empty (finish_empty)
    );

    fcrc_accum accum_i (
        .clk       (clk),
        .rst       (rst),
        .seed_en   (seed_en),
        .fold_en   (fold_en),
        .word      (fuse_rd_data_i),
        .crc_final (crc_final)
    );

    fcrc_status status_i (
        .clk          (clk),
        .rst          (rst),
        .launch       (launch),
        .ctl_wr       (ctl_wr),
        .ctl_fail_in  (ctl_fail_in),
        .finish_cmp   (finish_cmp),
        .finish_empty (finish_empty),
        .crc_final    (crc_final),
        .ref_word     (fuse_rd_data_i),
        .go           (go_o),
        .fail         (fail_o),
        .result       (crc_result_o)
    );

    // R2: configuration is frozen during a check
    assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(cfg_q));

    // R3: a check only begins after a go write
    assert_start_from_go_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(ctl_wr && ctl_go_in));

    // R8: go follows busy and clears itself
    assert_go_tracks_busy_R8: assert property (@(posedge clk) disable iff (rst)
        go_o == busy_o);

    // R10: no fuse read while idle
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !fuse_rd_en_o);
endmodule

// File: tb/fuse_crc_checker_tb_top.sv
module fuse_crc_checker_tb_top;
    localparam logic [31:0] POLY  = 32'hEDB88320;
    localparam int          BASE  = 8'hF0;
    localparam int          FIXED = 8'hE8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [19:0] cfg_wdata = '0;
    logic [19:0] cfg_rdata;
    logic        ctl_wr = 1'b0, ctl_go_in = 1'b0, ctl_fail_in = 1'b1;
    logic        go_o, busy_o, fail_o, fuse_rd_en_o;
    logic [31:0] crc_result_o;
    logic [7:0]  fuse_rd_addr_o;
    logic [31:0] fuse_rd_data_i = '0;

    logic [31:0] fmem [0:255];
    int checks = 0, errors = 0;
    int busy_cnt = 0, rd_cnt = 0;

    always #10 clk = ~clk;

    fuse_crc_checker dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ctl_wr(ctl_wr), .ctl_go_in(ctl_go_in),
        .ctl_fail_in(ctl_fail_in), .go_o(go_o), .busy_o(busy_o),
        .fail_o(fail_o), .crc_result_o(crc_result_o),
        .fuse_rd_en_o(fuse_rd_en_o), .fuse_rd_addr_o(fuse_rd_addr_o),
        .fuse_rd_data_i(fuse_rd_data_i)
    );

    always @(posedge clk) begin
        if (fuse_rd_en_o) fuse_rd_data_i <= fmem[fuse_rd_addr_o];
        if (busy_o) busy_cnt <= busy_cnt + 1;
        if (fuse_rd_en_o) rd_cnt <= rd_cnt + 1;
    end

    function automatic logic [31:0] model_crc(input int lo, input int hi);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int a = lo; a <= hi; a++) begin
            for (int b = 0; b < 4; b++) begin
                c = c ^ ((fmem[a] >> (8 * b)) & 32'hFF);
                for (int k = 0; k < 8; k++)
                    c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
            end
        end
        return ~c;
    endfunction

    function automatic int ref_loc(input int sel, input bit fx);
        return fx ? FIXED : (BASE + sel);
    endfunction

    function automatic logic [19:0] pack_cfg(input int lo, input int hi,
                                             input int sel, input bit fx);
        return {fx, sel[2:0], hi[7:0], lo[7:0]};
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [19:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic clr_fail();
        @(negedge clk); ctl_wr = 1'b1; ctl_go_in = 1'b0; ctl_fail_in = 1'b0;
        @(negedge clk); ctl_wr = 1'b0; ctl_fail_in = 1'b1;
    endtask

    task automatic launch();
        @(negedge clk);
        busy_cnt = 0; rd_cnt = 0;
        ctl_wr = 1'b1; ctl_go_in = 1'b1; ctl_fail_in = 1'b1;
        @(negedge clk); ctl_wr = 1'b0; ctl_go_in = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    task automatic run(input int lo, input int hi, input int sel, input bit fx);
        wr_cfg(pack_cfg(lo, hi, sel, fx));
        launch();
        wait_idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] e;
        int n;
        void'($urandom(32'h0000_C0DE));
        for (int i = 0; i < 256; i++) fmem[i] = $urandom;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!busy_o && !go_o && !fail_o, "R1 flags", {go_o, busy_o, fail_o}, 0);
        chk(crc_result_o == 0, "R1 result", crc_result_o, 0);
        chk(cfg_rdata == 0, "R1 cfg", cfg_rdata, 0);

        // R2: field layout readback
        wr_cfg(20'hA5C3F);
        chk(cfg_rdata == 20'hA5C3F, "R2 readback", cfg_rdata, 20'hA5C3F);

        // R3 / R4 / R5: single word, selector 2, correct reference
        e = model_crc(16, 16);
        fmem[ref_loc(2, 0)] = e;
        wr_cfg(pack_cfg(16, 16, 2, 0));
        @(negedge clk); busy_cnt = 0; rd_cnt = 0;
        ctl_wr = 1'b1; ctl_go_in = 1'b1;
        @(negedge clk); ctl_wr = 1'b0; ctl_go_in = 1'b0;
        chk(busy_o && go_o, "R3 go and busy rise", {go_o, busy_o}, 3);
        wait_idle();
        chk(crc_result_o == e, "R4 single word crc", crc_result_o, e);
        chk(!fail_o, "R5 match leaves fail clear", fail_o, 0);
        chk(busy_cnt == 4, "R8 busy cycles N=1", busy_cnt, 4);
        chk(!go_o, "R8 go self clears", go_o, 0);
        chk(rd_cnt == 2, "R10 reads N=1", rd_cnt, 2);

        // R5: fixed location with wrong reference sets fail
        e = model_crc(3, 9);
        fmem[FIXED] = ~e;
        fmem[ref_loc(5, 0)] = e;
        run(3, 9, 5, 1);
        chk(crc_result_o == e, "R4 seven words", crc_result_o, e);
        chk(fail_o, "R5 fixed location mismatch", fail_o, 1);
        chk(busy_cnt == 16, "R8 busy cycles N=7", busy_cnt, 16);
        chk(rd_cnt == 8, "R10 reads N=7", rd_cnt, 8);

        // R6: sticky across a matching check, write 1 no effect, write 0 clears
        fmem[FIXED] = e;
        run(3, 9, 5, 1);
        chk(fail_o, "R6 sticky after match", fail_o, 1);
        @(negedge clk); ctl_wr = 1'b1; ctl_fail_in = 1'b1;
        @(negedge clk); ctl_wr = 1'b0;
        chk(fail_o, "R6 write one keeps", fail_o, 1);
        clr_fail();
        chk(!fail_o, "R6 write zero clears", fail_o, 0);

        // R7: empty window
        run(40, 39, 0, 0);
        chk(fail_o, "R7 empty fails", fail_o, 1);
        chk(crc_result_o == 0, "R7 empty result", crc_result_o, 0);
        chk(busy_cnt == 1, "R7 busy one cycle", busy_cnt, 1);
        chk(rd_cnt == 0, "R7 no reads", rd_cnt, 0);
        clr_fail();

        // R2 / R3: writes during a check are ignored
        e = model_crc(20, 22);
        fmem[ref_loc(1, 0)] = e;
        wr_cfg(pack_cfg(20, 22, 1, 0));
        launch();
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = pack_cfg(0, 50, 7, 1);
        ctl_wr = 1'b1; ctl_go_in = 1'b1;
        @(negedge clk); cfg_wr = 1'b0; ctl_wr = 1'b0; ctl_go_in = 1'b0;
        wait_idle();
        chk(cfg_rdata == pack_cfg(20, 22, 1, 0), "R2 cfg frozen", cfg_rdata,
            pack_cfg(20, 22, 1, 0));
        chk(busy_cnt == 8, "R3 no restart", busy_cnt, 8);
        chk(crc_result_o == e && !fail_o, "R3 result intact", crc_result_o, e);

        // R9: clear lands in the comparison cycle, mismatch wins
        n = 2;
        fmem[ref_loc(4, 0)] = ~model_crc(30, 31);
        wr_cfg(pack_cfg(30, 31, 4, 0));
        launch();
        repeat (2 * n + 1) @(negedge clk);
        ctl_wr = 1'b1; ctl_fail_in = 1'b0;
        @(negedge clk); ctl_wr = 1'b0; ctl_fail_in = 1'b1;
        chk(!busy_o && fail_o, "R9 set beats clear", fail_o, 1);
        // R9: clear in the comparison cycle of a matching check wins
        fmem[ref_loc(4, 0)] = model_crc(30, 31);
        launch();
        repeat (2 * n + 1) @(negedge clk);
        ctl_wr = 1'b1; ctl_fail_in = 1'b0;
        @(negedge clk); ctl_wr = 1'b0; ctl_fail_in = 1'b1;
        chk(!busy_o && !fail_o, "R9 clear with match", fail_o, 0);

        // R4: top of the address space
        e = model_crc(253, 255);
        fmem[ref_loc(6, 0)] = e;
        run(253, 255, 6, 0);
        chk(crc_result_o == e && !fail_o, "R4 window at top", crc_result_o, e);

        // R4 / R5: random windows
        for (int t = 0; t < 24; t++) begin
            int lo, hi, sel;
            bit fx, good;
            lo  = $urandom % 200;
            hi  = lo + ($urandom % 12);
            sel = $urandom % 8;
            fx  = $urandom % 2;
            good = $urandom % 2;
            e = model_crc(lo, hi);
            fmem[ref_loc(sel, fx)] = good ? e : (e ^ 32'h0000_0100);
            clr_fail();
            run(lo, hi, sel, fx);
            chk(crc_result_o == e, "R4 random crc", crc_result_o, e);
            chk(fail_o == !good, "R5 random compare", fail_o, !good);
            chk(busy_cnt == 2 * (hi - lo + 1) + 2, "R8 random busy", busy_cnt,
                2 * (hi - lo + 1) + 2);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule